// File: doc/BRIEF.md
# Filtered Latched Fault Supervisor

This block watches the raw outputs of a motor-bridge driver's fault comparators and decides when each fault counts. Every raw input passes through a two-flop synchronizer and a minimum-duration filter: a counter that climbs while the input stays high, restarts at zero the moment it drops, and saturates at its threshold. Overcurrent inputs, one per half-bridge driver, use a short threshold; open load (one per bridge), supply overvoltage, supply undervoltage, temperature warning and thermal shutdown use a longer one. A filtered fault sets a sticky status bit, and the set of sticky bits decides which drivers may run and whether all outputs are put into high impedance.

The host reaches the block through a 16-bit serial frame (clock idles low, data sampled on the rising clock edge and changed on the falling edge, most significant bit first) framed by an active-low chip select. The serial pins are oversampled by the block clock. The word shifted out is a snapshot taken when chip select falls. The word shifted in carries a write-one-to-clear mask and an optional overvoltage-policy write, applied when chip select rises, and only if the frame held exactly 16 clock pulses. A low enable input clears every register and forces the outputs off.

The serial link is a state machine with three states. `LINK_IDLE` waits; the transition *frame start* (chip select seen falling) loads the snapshot and enters `LINK_SHIFT`. In `LINK_SHIFT`, *frame end* (chip select seen rising) goes to `LINK_COMMIT` when exactly 16 bits were received, and *frame abort* goes back to `LINK_IDLE` otherwise. `LINK_COMMIT` lasts one cycle, presents the received word to the status logic, and returns to `LINK_IDLE` through *commit done*. Enable low forces `LINK_IDLE` from any state.

Top module: `fault_supervisor`

## Requirements
- R1: A raw fault input that is high for N consecutive block clock cycles sets its status bit if and only if N is at least its threshold: OC_FILT_CYC for overcurrent inputs and DIAG_FILT_CYC for all others. A shorter pulse leaves no trace, because the count restarts when the input drops.
- R2: Status bits are sticky and hold after the raw input has gone low. Positions: bits 3..0 overcurrent of driver 3..0, bits 5..4 open load of bridge 1..0, bit 6 overvoltage, bit 7 undervoltage, bit 8 temperature warning, bit 9 thermal shutdown.
- R3: A latched overcurrent on driver i drives `drv_en[i]` low and leaves the other drivers and `out_hiz` unchanged.
- R4: Latched open-load and temperature-warning bits have no effect on `drv_en` or `out_hiz`.
- R5: A latched overvoltage raises `out_hiz` and drops all `drv_en` when the overvoltage policy bit is 0, which is its reset value. When the bit is 1, overvoltage only sets its status bit.
- R6: A latched undervoltage or thermal shutdown raises `out_hiz` and drops all `drv_en`.
- R7: When a complete frame ends, each status bit whose position in the received word's bits 9..0 holds a 1 is cleared and the others are kept. A bit whose filtered fault is still active in that cycle stays set.
- R8: The thermal shutdown bit ignores a clear while the synchronized raw thermal shutdown input is high. The clear works once that input is low.
- R9: A frame is 16 bits, most significant bit first. The returned word is captured at chip select fall: bit 15 is `out_hiz`, bit 14 is the overvoltage policy bit, bits 13..10 are zero, and bits 9..0 are the status. `spi_miso_oe` is high only while a frame is in progress.
- R10: A complete frame with received bit 15 set writes received bit 14 into the overvoltage policy bit. With bit 15 clear, the policy bit keeps its value.
- R11: A frame with any count of rising serial-clock edges other than 16 changes no status or policy bit.
- R12: After reset, and whenever `en` is low, all status bits and the policy bit are zero, `out_hiz` is high, every `drv_en` is low and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| en | input | 1 | Active-high enable; low clears all state and forces outputs off |
| oc_raw | input | NUM_DRV (4) | Raw overcurrent comparator, one per half-bridge driver |
| ol_raw | input | NUM_BRG (2) | Raw open-load indication, one per bridge |
| ov_raw | input | 1 | Raw supply overvoltage comparator |
| uv_raw | input | 1 | Raw supply undervoltage comparator |
| tw_raw | input | 1 | Raw temperature warning comparator |
| tsd_raw | input | 1 | Raw thermal shutdown comparator (includes hysteresis) |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| drv_en | output | NUM_DRV (4) | Per-driver run permission |
| out_hiz | output | 1 | Put every bridge output into high impedance |

## Verification
The bench drives fault pulses one cycle shorter than, equal to and slightly longer than each threshold. A filter that counted one cycle off, or that kept its count across a gap, would latch the short pulse or miss the exact one. It holds an overvoltage active through a clear to show that a still-present fault wins over the clear, and it re-raises thermal shutdown below its threshold during a clear, where a design that ignored the input level would drop `out_hiz` early. A half-length frame carrying an all-ones mask would wipe the status in a design that committed on any chip select rise. The policy write is tried with its write bit both clear and set to catch an ungated write.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    localparam int NUM_DRV = 4;
    localparam int NUM_BRG = 2;
    localparam int NUM_FLT = NUM_DRV + NUM_BRG + 4;
    localparam int FRAME_W = 16;

    localparam int BIT_OV  = NUM_DRV + NUM_BRG;
    localparam int BIT_UV  = BIT_OV + 1;
    localparam int BIT_TW  = BIT_OV + 2;
    localparam int BIT_TSD = BIT_OV + 3;

    localparam int BIT_CFG_WR  = FRAME_W - 1;
    localparam int BIT_OV_MODE = FRAME_W - 2;

    typedef enum logic [1:0] {
        LINK_IDLE   = 2'd0,
        LINK_SHIFT  = 2'd1,
        LINK_COMMIT = 2'd2
    } link_state_t;
endpackage

// File: rtl/fsup_filter.sv
module fsup_filter #(
    parameter int TH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw_i,
    output logic hit_o
);
    localparam int CW = $clog2(TH + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(TH);

    logic [1:0]    sq;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq <= {sq[0], raw_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !sq[1]) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign hit_o = (cnt == CNT_TOP);
endmodule

// File: rtl/fsup_link.sv
module fsup_link
    import fsup_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sclk_i,
    input  logic          csn_i,
    input  logic          mosi_i,
    input  logic [FW-1:0] rd_word,
    output logic          miso_o,
    output logic          miso_oe_o,
    output logic          cmd_stb,
    output logic [FW-1:0] cmd_word
);
    localparam int CNT_W = $clog2(FW + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);

    link_state_t     state, state_nx;
    logic [2:0]      sclk_q, csn_q;
    logic [1:0]      mosi_q;
    logic [FW-1:0]   tx_sr, rx_sr;
    logic [CNT_W-1:0] bit_cnt;
    logic            sclk_rise, sclk_fall, cs_start, cs_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk_i};
            csn_q  <= {csn_q[1:0], csn_i};
            mosi_q <= {mosi_q[0], mosi_i};
        end
    end

    always_comb begin
        sclk_rise = sclk_q[1] && !sclk_q[2];
        sclk_fall = !sclk_q[1] && sclk_q[2];
        cs_start  = !csn_q[1] && csn_q[2];
        cs_end    = csn_q[1] && !csn_q[2];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LINK_IDLE;
        end else if (clr) begin
            state <= LINK_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions: frame start, frame end, frame abort, commit done
    always_comb begin
        state_nx = state;
        unique case (state)
            LINK_IDLE: begin
                if (cs_start) state_nx = LINK_SHIFT;
            end
            LINK_SHIFT: begin
                if (cs_end) state_nx = (bit_cnt == CNT_FULL) ? LINK_COMMIT : LINK_IDLE;
            end
            LINK_COMMIT: begin
                state_nx = LINK_IDLE;
            end
            default: begin
                state_nx = LINK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (clr) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (state == LINK_IDLE && cs_start) begin
            tx_sr   <= rd_word;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else if (state == LINK_SHIFT) begin
            if (sclk_rise) begin
                rx_sr <= {rx_sr[FW-2:0], mosi_q[1]};
                if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (sclk_fall) begin
                tx_sr <= {tx_sr[FW-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        miso_o    = tx_sr[FW-1];
        miso_oe_o = (state == LINK_SHIFT);
        cmd_stb   = (state == LINK_COMMIT);
        cmd_word  = rx_sr;
    end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int OC_FILT_CYC   = 8,
    parameter int DIAG_FILT_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [NUM_DRV-1:0] oc_raw,
    input  logic [NUM_BRG-1:0] ol_raw,
    input  logic               ov_raw,
    input  logic               uv_raw,
    input  logic               tw_raw,
    input  logic               tsd_raw,
    input  logic               spi_sclk,
    input  logic               spi_csn,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               spi_miso_oe,
    output logic [NUM_DRV-1:0] drv_en,
    output logic               out_hiz
);
    localparam int PAD_W = FRAME_W - NUM_FLT - 2;

    logic               clr;
    logic [NUM_FLT-1:0] raw_vec, hit, stat, wipe;
    logic               ov_mode;
    logic [1:0]         tsd_sq;
    logic               cmd_stb;
    logic [FRAME_W-1:0] cmd_word, rd_word;
    logic               rsvd_unused;

    assign clr     = !en;
    assign raw_vec = {tsd_raw, tw_raw, uv_raw, ov_raw, ol_raw, oc_raw};

    for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
        localparam int TH = (g < NUM_DRV) ? OC_FILT_CYC : DIAG_FILT_CYC;
        fsup_filter #(.TH(TH)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .raw_i (raw_vec[g]),
            .hit_o (hit[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsd_sq <= '0;
        end else begin
            tsd_sq <= {tsd_sq[0], tsd_raw};
        end
    end

    fsup_link #(.FW(FRAME_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .sclk_i    (spi_sclk),
        .csn_i     (spi_csn),
        .mosi_i    (spi_mosi),
        .rd_word   (rd_word),
        .miso_o    (spi_miso),
        .miso_oe_o (spi_miso_oe),
        .cmd_stb   (cmd_stb),
        .cmd_word  (cmd_word)
    );

    assign rsvd_unused = &{1'b0, cmd_word[FRAME_W-3:NUM_FLT]};

    always_comb begin
        wipe = '0;
        if (cmd_stb) wipe = cmd_word[NUM_FLT-1:0];
        if (tsd_sq[1]) wipe[BIT_TSD] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else if (clr) begin
            stat <= '0;
        end else begin
            stat <= (stat & ~wipe) | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_mode <= 1'b0;
        end else if (clr) begin
            ov_mode <= 1'b0;
        end else if (cmd_stb && cmd_word[BIT_CFG_WR]) begin
            ov_mode <= cmd_word[BIT_OV_MODE];
        end
    end

    always_comb begin
        out_hiz = clr || stat[BIT_UV] || stat[BIT_TSD] || (stat[BIT_OV] && !ov_mode);
        drv_en  = out_hiz ? '0 : ~stat[NUM_DRV-1:0];
        rd_word = {out_hiz, ov_mode, {PAD_W{1'b0}}, stat};
    end
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk
    import fsup_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [NUM_FLT-1:0] stat,
    input logic               ov_mode,
    input logic               tsd_hold,
    input logic               cmd_stb,
    input logic [NUM_DRV-1:0] drv_en,
    input logic               out_hiz,
    input logic               miso_oe
);
    localparam logic [NUM_FLT-1:0] INFO_MASK =
        NUM_FLT'((1 << BIT_TW) | (((1 << NUM_BRG) - 1) << NUM_DRV));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cmd_stb) |=> (!en || ((stat & $past(stat)) == $past(stat))));

    assert_info_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ((stat & ~INFO_MASK) == '0)) |-> (drv_en == '1 && !out_hiz));

    assert_tsd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stat[BIT_TSD] && tsd_hold) |=> (!en || stat[BIT_TSD]));

    assert_commit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cmd_stb) |=> (!en || $stable(ov_mode)));

    assert_off_outputs_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (out_hiz && drv_en == '0));

    assert_off_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (stat == '0 && !ov_mode && !miso_oe));
endmodule

bind fault_supervisor fault_supervisor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .stat     (stat),
    .ov_mode  (ov_mode),
    .tsd_hold (tsd_sq[1]),
    .cmd_stb  (cmd_stb),
    .drv_en   (drv_en),
    .out_hiz  (out_hiz),
    .miso_oe  (spi_miso_oe)
);

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
    import fsup_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int OC_TH      = 8;
    localparam int DIAG_TH    = 400;

    logic       clk = 1'b0;
    logic       rst_n, en;
    logic [9:0] raw;
    logic       sclk, csn, mosi;
    logic       miso, miso_oe, out_hiz;
    logic [3:0] drv_en;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    logic oe_mid;
    logic [15:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fault_supervisor #(.OC_FILT_CYC(OC_TH), .DIAG_FILT_CYC(DIAG_TH)) i_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .en(en),
        .oc_raw(raw[3:0]), .ol_raw(raw[5:4]), .ov_raw(raw[6]), .uv_raw(raw[7]),
        .tw_raw(raw[8]), .tsd_raw(raw[9]),
        .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .drv_en(drv_en), .out_hiz(out_hiz)
    );

    function automatic logic exp_hiz(input logic [9:0] s, input logic m, input logic e);
        return !e || s[7] || s[9] || (s[6] && !m);
    endfunction

    function automatic logic [3:0] exp_drv(input logic [9:0] s, input logic m, input logic e);
        return exp_hiz(s, m, e) ? 4'h0 : ~s[3:0];
    endfunction

    function automatic logic [15:0] exp_word(input logic [9:0] s, input logic m);
        return {exp_hiz(s, m, 1'b1), m, 4'b0000, s};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] wr, input int nbits, output logic [15:0] got);
        got = '0;
        csn = 1'b0;
        tick(4);
        for (int b = 0; b < nbits; b++) begin
            mosi = wr[15-b];
            tick(4);
            got[15-b] = miso;
            if (b == 3) oe_mid = miso_oe;
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        csn  = 1'b1;
        mosi = 1'b0;
        tick(6);
    endtask

    task automatic pulse(input int idx, input int len);
        raw[idx] = 1'b1;
        tick(len);
        raw[idx] = 1'b0;
        tick(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] m_stat;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; en = 1'b0; raw = '0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0;
        tick(3);
        chk("R12 hiz in reset", {31'b0, out_hiz}, 32'd1);
        rst_n = 1'b1; en = 1'b1;
        tick(4);
        chk("R12 drv after reset", {28'b0, drv_en}, 32'hF);
        chk("R12 hiz after reset", {31'b0, out_hiz}, 32'd0);
        chk("R12 oe idle", {31'b0, miso_oe}, 32'd0);

        // R1 overcurrent boundary and R3 isolation
        pulse(1, OC_TH - 1);
        chk("R1 short oc pulse", {28'b0, drv_en}, 32'hF);
        pulse(2, OC_TH);
        chk("R3 oc driver 2", {28'b0, drv_en}, 32'hB);
        chk("R3 no hiz", {31'b0, out_hiz}, 32'd0);
        frame(16'h03FF, 16, rd);
        chk("R2 read oc", {16'b0, rd}, 32'h0004);
        chk("R9 oe mid frame", {31'b0, oe_mid}, 32'd1);
        chk("R9 oe after frame", {31'b0, miso_oe}, 32'd0);
        chk("R7 drv after clear", {28'b0, drv_en}, 32'hF);

        // R1 diag boundary, R4 warning, R2 sticky
        pulse(8, DIAG_TH - 1);
        frame(16'h0000, 16, rd);
        chk("R1 short warn pulse", {16'b0, rd}, 32'h0000);
        pulse(8, DIAG_TH);
        chk("R4 warn drv", {28'b0, drv_en}, 32'hF);
        chk("R4 warn hiz", {31'b0, out_hiz}, 32'd0);
        frame(16'h0000, 16, rd);
        chk("R2 warn sticky", {16'b0, rd}, 32'h0100);
        frame(16'h0100, 16, rd);
        frame(16'h0000, 16, rd);
        chk("R7 warn cleared", {16'b0, rd}, 32'h0000);
        pulse(5, DIAG_TH);
        chk("R4 open load drv", {28'b0, drv_en}, 32'hF);
        frame(16'h03FF, 16, rd);
        chk("R2 open load bit", {16'b0, rd}, 32'h0020);

        // R5 overvoltage policies, R10 config write
        pulse(6, DIAG_TH);
        chk("R5 ov hiz", {31'b0, out_hiz}, 32'd1);
        chk("R5 ov drv", {28'b0, drv_en}, 32'h0);
        frame(16'hC3FF, 16, rd);
        chk("R9 word ov", {16'b0, rd}, 32'h8040);
        pulse(6, DIAG_TH);
        chk("R5 flag only hiz", {31'b0, out_hiz}, 32'd0);
        chk("R5 flag only drv", {28'b0, drv_en}, 32'hF);
        frame(16'h83FF, 16, rd);
        chk("R10 mode set", {16'b0, rd}, 32'h4040);
        frame(16'h4000, 16, rd);
        frame(16'h0000, 16, rd);
        chk("R10 ungated write", {16'b0, rd}, 32'h0000);

        // R7 active fault wins over clear
        raw[6] = 1'b1;
        tick(DIAG_TH + 10);
        frame(16'hC3FF, 16, rd);
        chk("R7 read before", {16'b0, rd}, 32'h8040);
        frame(16'h0000, 16, rd);
        chk("R7 still active", {16'b0, rd}, 32'h4040);
        raw[6] = 1'b0;
        tick(2);
        frame(16'h83FF, 16, rd);
        frame(16'h0000, 16, rd);
        chk("R7 cleared", {16'b0, rd}, 32'h0000);

        // R6 undervoltage
        pulse(7, DIAG_TH);
        chk("R6 uv hiz", {31'b0, out_hiz}, 32'd1);
        chk("R6 uv drv", {28'b0, drv_en}, 32'h0);
        frame(16'h03FF, 16, rd);
        chk("R6 uv word", {16'b0, rd}, 32'h8080);

        // R8 thermal shutdown hold
        pulse(9, DIAG_TH);
        chk("R6 tsd hiz", {31'b0, out_hiz}, 32'd1);
        raw[9] = 1'b1;
        tick(2);
        frame(16'h03FF, 16, rd);
        chk("R8 tsd word", {16'b0, rd}, 32'h8200);
        chk("R8 hold while hot", {31'b0, out_hiz}, 32'd1);
        raw[9] = 1'b0;
        tick(4);
        frame(16'h0000, 16, rd);
        chk("R8 still latched", {16'b0, rd}, 32'h8200);
        frame(16'h03FF, 16, rd);
        chk("R8 released hiz", {31'b0, out_hiz}, 32'd0);
        chk("R8 released drv", {28'b0, drv_en}, 32'hF);

        // R11 partial frame
        pulse(0, OC_TH);
        frame(16'hFFFF, 8, rd);
        chk("R11 partial drv", {28'b0, drv_en}, 32'hE);
        frame(16'h0000, 16, rd);
        chk("R11 partial word", {16'b0, rd}, 32'h0001);
        frame(16'h03FF, 16, rd);

        // R12 enable low
        pulse(1, OC_TH);
        frame(16'hC000, 16, rd);
        chk("R12 pre word", {16'b0, rd}, 32'h0002);
        en = 1'b0;
        tick(2);
        chk("R12 en low hiz", {31'b0, out_hiz}, 32'd1);
        chk("R12 en low drv", {28'b0, drv_en}, 32'h0);
        chk("R12 en low oe", {31'b0, miso_oe}, 32'd0);
        en = 1'b1;
        tick(4);
        frame(16'h0000, 16, rd);
        chk("R12 cleared word", {16'b0, rd}, 32'h0000);

        // random pulses around the thresholds (policy bit 0)
        m_stat = '0;
        for (int it = 0; it < 30; it++) begin
            int idx, th, len;
            idx = $urandom_range(0, 9);
            th  = (idx < 4) ? OC_TH : DIAG_TH;
            len = th - 2 + $urandom_range(0, 4);
            pulse(idx, len);
            if (len >= th) m_stat[idx] = 1'b1;
            chk("R6 random hiz", {31'b0, out_hiz}, {31'b0, exp_hiz(m_stat, 1'b0, 1'b1)});
            chk("R3 random drv", {28'b0, drv_en}, {28'b0, exp_drv(m_stat, 1'b0, 1'b1)});
            frame(16'h03FF, 16, rd);
            chk("R1 random word", {16'b0, rd}, {16'b0, exp_word(m_stat, 1'b0)});
            m_stat = '0;
            chk("R7 random clear", {28'b0, drv_en}, 32'hF);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule